// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block collects interrupt requests from up to 32 sources and turns them into one interrupt line for a processor plus a wake indication that releases the processor from a halted state. It keeps three pieces of state: a per-source enable mask, a per-source pending mask, and a master enable word. Software reaches all three through a narrow 16-bit register port, so each 32-bit mask is split into a low and a high half.

Peripherals signal an event by pulsing their bit of the raise vector for one clock. The event is latched into the pending mask. The interrupt line is a level that stays high while the master enable word is nonzero and at least one source is both enabled and pending. A write to the enable mask or to the master word takes effect at once, so the line can rise straight after such a write. The wake output responds only to the enable mask and does not look at the master word. Software acknowledges an event by writing a 1 to its pending bit.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable mask, the pending mask and the master word all read as zero, and the interrupt and wake outputs are low.
- R2: A pulse on raise bit k sets pending bit k at the next clock edge. Sources 0 to 15 land in the pending low half (address 2) and sources 16 to 31 in the pending high half (address 3).
- R3: Writing a pending half clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When a raise pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: The interrupt output is high exactly when the master word is nonzero and some bit is set in both the enable mask and the pending mask. Any nonzero master value counts, including 0x8000.
- R6: With the master word nonzero, a write to an enable half that covers an already pending bit raises the interrupt output in the cycle after the write.
- R7: Writing a nonzero master word while enable and pending overlap raises the interrupt output in the cycle after the write. Writing zero lowers it.
- R8: A raise pulse on a source that is enabled in the enable mask drives the wake output high for exactly the next cycle, whatever the master word holds. A raise pulse on a disabled source leaves the wake output low.
- R9: Clearing the last pending bit that overlaps the enable mask lowers the interrupt output in the next cycle.
- R10: The register addresses are 0 for enable low, 1 for enable high, 2 for pending low, 3 for pending high and 4 for the master word. Addresses 5 to 7 read as zero, and writes to them change no state.
- R11: A write to an enable half or to the master word stores all 16 bits, and a read returns exactly the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from address |
| src_raise | input | 32 | Per-source one-cycle event pulses |
| irq_out | output | 1 | Level interrupt request to the processor |
| wake_out | output | 1 | One-cycle pulse that ends a halt |

## Verification
The bench targets the points where the wake and interrupt paths part. It raises an enabled source while the master word is zero. A design that gated wake with the master word would stay silent here, and one that let the event through to the interrupt line would fire too early. It clears a pending bit in the same cycle that bit is raised again. A design that gave the clear priority would lose the event. It writes the enable mask and the master word while events are already pending, and a design that only checked for interrupts when a new event arrived would miss them. It also uses a master value with only bit 15 set, to catch a design that tested only the low bit. Unmapped addresses are written and then read back to expose decode aliasing. A long random run is compared against a reference model that the bench keeps.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int HALF_W      = 16;
    localparam int SRC_N       = 32;
    localparam int HALF_N      = SRC_N / HALF_W;
    localparam int EN_BASE     = 0;
    localparam int PEND_BASE   = HALF_N;
    localparam int MASTER_ADDR = 2 * HALF_N;
    localparam int ADDR_W      = $clog2(MASTER_ADDR + 1);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [HALF_W-1:0] wdata;
    } bus_wr_t;

    function automatic logic hits(input bus_wr_t wr, input int target);
        return wr.we && (wr.addr == ADDR_W'(target));
    endfunction
endpackage

// File: rtl/irqc_enables.sv
module irqc_enables
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           wr,
    output logic [SRC_N-1:0]  ie_q,
    output logic [HALF_W-1:0] ime_q
);
    for (genvar h = 0; h < HALF_N; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                ie_q[h*HALF_W +: HALF_W] <= '0;
            end else if (hits(wr, EN_BASE + h)) begin
                ie_q[h*HALF_W +: HALF_W] <= wr.wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ime_q <= '0;
        end else if (hits(wr, MASTER_ADDR)) begin
            ime_q <= wr.wdata;
        end
    end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_wr_t          wr,
    input  logic [SRC_N-1:0] raise,
    output logic [SRC_N-1:0] if_q
);
    for (genvar h = 0; h < HALF_N; h++) begin : g_half
        logic [HALF_W-1:0] clr;
        logic [HALF_W-1:0] nxt;

        always_comb begin
            clr = hits(wr, PEND_BASE + h) ? wr.wdata : '0;
            // a new event outranks the acknowledge of the same bit
            nxt = (if_q[h*HALF_W +: HALF_W] & ~clr) | raise[h*HALF_W +: HALF_W];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                if_q[h*HALF_W +: HALF_W] <= '0;
            end else begin
                if_q[h*HALF_W +: HALF_W] <= nxt;
            end
        end
    end
endmodule

// File: rtl/irqc_signal.sv
module irqc_signal
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  raise,
    input  logic [SRC_N-1:0]  ie_q,
    input  logic [SRC_N-1:0]  if_q,
    input  logic [HALF_W-1:0] ime_q,
    output logic              irq,
    output logic              wake
);
    logic [HALF_N-1:0] half_hit;

    for (genvar h = 0; h < HALF_N; h++) begin : g_half
        assign half_hit[h] = |(ie_q[h*HALF_W +: HALF_W] & if_q[h*HALF_W +: HALF_W]);
    end

    assign irq = (ime_q != '0) && (half_hit != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wake <= 1'b0;
        end else begin
            wake <= |(raise & ie_q);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [HALF_W-1:0]   bus_wdata,
    output logic [HALF_W-1:0]   bus_rdata,
    input  logic [SRC_N-1:0]    src_raise,
    output logic                irq_out,
    output logic                wake_out
);
    bus_wr_t           wr;
    logic [SRC_N-1:0]  ie_q;
    logic [SRC_N-1:0]  if_q;
    logic [HALF_W-1:0] ime_q;

    assign wr = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};

    irqc_enables u_en (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .ie_q (ie_q),
        .ime_q(ime_q)
    );

    irqc_pending u_pend (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .raise(src_raise),
        .if_q (if_q)
    );

    irqc_signal u_sig (
        .clk  (clk),
        .rst  (rst),
        .raise(src_raise),
        .ie_q (ie_q),
        .if_q (if_q),
        .ime_q(ime_q),
        .irq  (irq_out),
        .wake (wake_out)
    );

    always_comb begin
        bus_rdata = '0;
        for (int h = 0; h < HALF_N; h++) begin
            if (bus_addr == ADDR_W'(EN_BASE + h))
                bus_rdata = ie_q[h*HALF_W +: HALF_W];
            if (bus_addr == ADDR_W'(PEND_BASE + h))
                bus_rdata = if_q[h*HALF_W +: HALF_W];
        end
        if (bus_addr == ADDR_W'(MASTER_ADDR))
            bus_rdata = ime_q;
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [HALF_W-1:0] bus_wdata,
    input logic [SRC_N-1:0]  src_raise,
    input logic [SRC_N-1:0]  ie_q,
    input logic [SRC_N-1:0]  if_q,
    input logic [HALF_W-1:0] ime_q,
    input logic              irq_out,
    input logic              wake_out
);
    p_raise_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (src_raise != '0) |=> ((if_q & $past(src_raise)) == $past(src_raise)));

    p_clear_lo_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(PEND_BASE) && src_raise[HALF_W-1:0] == '0)
        |=> ((if_q[HALF_W-1:0] & $past(bus_wdata)) == '0));

    p_irq_needs_master_r5: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (ime_q != '0));

    p_enable_write_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(EN_BASE) && ime_q != '0
         && (bus_wdata & if_q[HALF_W-1:0]) != '0) |=> irq_out);

    p_master_write_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(MASTER_ADDR) && bus_wdata != '0
         && (ie_q & if_q) != '0) |=> irq_out);

    p_wake_cause_r8: assert property (@(posedge clk) disable iff (rst)
        wake_out |-> $past(src_raise != '0));

    p_no_pending_r9: assert property (@(posedge clk) disable iff (rst)
        (if_q == '0) |-> !irq_out);
endmodule

bind irqc_top irqc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .src_raise(src_raise),
    .ie_q     (ie_q),
    .if_q     (if_q),
    .ime_q    (ime_q),
    .irq_out  (irq_out),
    .wake_out (wake_out)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] src_raise = '0;
    logic        irq_out;
    logic        wake_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] m_ie  = '0;
    logic [31:0] m_if  = '0;
    logic [15:0] m_ime = '0;
    logic        m_wake = 1'b0;

    always #5 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_raise(src_raise),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_ie[15:0];
            3'd1: return m_ie[31:16];
            3'd2: return m_if[15:0];
            3'd3: return m_if[31:16];
            3'd4: return m_ime;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_ime != 16'h0) && ((m_ie & m_if) != 32'h0);
    endfunction

    // called right after a falling edge; returns right after the next one
    task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d,
                        input logic [31:0] r);
        logic [31:0] clr;
        bus_we = we; bus_addr = a; bus_wdata = d; src_raise = r;
        m_wake = |(r & m_ie);
        clr = '0;
        if (we && a == 3'd2) clr[15:0]  = d;
        if (we && a == 3'd3) clr[31:16] = d;
        m_if = (m_if & ~clr) | r;
        if (we && a == 3'd0) m_ie[15:0]  = d;
        if (we && a == 3'd1) m_ie[31:16] = d;
        if (we && a == 3'd4) m_ime = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; src_raise = '0;
    endtask

    task automatic rd(input string req, input logic [2:0] a);
        bus_addr = a;
        #1;
        chk(req, {16'h0, bus_rdata}, {16'h0, exp_rd(a)});
    endtask

    task automatic outs(input string req);
        chk({req, " irq"}, {31'h0, irq_out}, {31'h0, exp_irq()});
        chk({req, " wake"}, {31'h0, wake_out}, {31'h0, m_wake});
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) rd("R1 reset reg", 3'(a));
        chk("R1 irq", {31'h0, irq_out}, 32'h0);
        chk("R1 wake", {31'h0, wake_out}, 32'h0);

        // R2 halves, R8 disabled source gives no wake
        step(1'b0, 3'd0, 16'h0, 32'h0000_0008);
        outs("R8 disabled");
        rd("R2 low half", 3'd2);
        step(1'b0, 3'd0, 16'h0, 32'h0010_0000);
        rd("R2 high half", 3'd3);

        // R11 enable readback, R5 master zero blocks irq
        step(1'b1, 3'd0, 16'h0008, 32'h0);
        rd("R11 enable low", 3'd0);
        outs("R5 master zero");

        // R8 wake without master
        step(1'b0, 3'd0, 16'h0, 32'h0000_0008);
        outs("R8 wake no master");
        outs("R8 pulse ends");
        step(1'b0, 3'd0, 16'h0, 32'h0);
        outs("R8 single cycle");

        // R7 master write
        step(1'b1, 3'd4, 16'h0001, 32'h0);
        outs("R7 master on");
        step(1'b1, 3'd4, 16'h0000, 32'h0);
        outs("R7 master off");
        step(1'b1, 3'd4, 16'h8000, 32'h0);
        outs("R5 master bit15");
        rd("R11 master", 3'd4);

        // R9 clear drops irq
        step(1'b1, 3'd2, 16'h0008, 32'h0);
        outs("R9 cleared");
        rd("R3 cleared bit", 3'd2);

        // R6 enable write with pending high source
        step(1'b1, 3'd1, 16'h0010, 32'h0);
        outs("R6 enable write");

        // R4 raise wins over clear
        step(1'b1, 3'd3, 16'h0010, 32'h0010_0000);
        rd("R4 raise wins", 3'd3);
        outs("R4 irq held");

        // R3 zero write no effect
        step(1'b1, 3'd3, 16'h0000, 32'h0);
        rd("R3 zero write", 3'd3);

        // R10 unmapped addresses
        for (int a = 5; a < 8; a++) begin
            step(1'b1, 3'(a), 16'hFFFF, 32'h0);
            rd("R10 unmapped read", 3'(a));
            for (int b = 0; b < 5; b++) rd("R10 no side effect", 3'(b));
        end

        // random mix against model
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom & $urandom & $urandom;
            if (($urandom % 3) == 0) r = '0;
            step(1'($urandom), 3'($urandom_range(0, 7)), 16'($urandom & $urandom), r);
            outs("R5 R8 random");
            if ((i % 4) == 0)
                for (int a = 0; a < 8; a++) rd("R2 R3 R4 R10 random read", 3'(a));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule